// File: doc/BRIEF.md
# Selectable-Interval Timer Carry and Interrupt Generator

The block divides the system clock into three square-wave time bases: fast (5 ms period), mid (20 ms) and slow (100 ms). A 4-bit mode register picks one of these, or an external zero-cross input, as the source for each of two functions. The first is a carry flag. It is set on the rising edge of its source and holds until software tests it. The second is an interrupt request. It is a single-cycle pulse raised by the falling edge of its source.

The carry flag starts at zero after reset and stays there until its first set edge. Start-up software can read it to tell a cold power-up from a warm chip-enable reset. A program-start strobe rises on the first rising edge of the slow time base after reset. A rising edge on the chip-enable input does not act at once. It is held pending and released as a one-cycle reset pulse on the next carry set event.

Top module: `tmr_carry_int`

## Requirements
- R1: During and right after reset, carry_rd_o, irq_o, run_o and ce_rst_o are 0 and the mode register holds 0.
- R2: With H = HALF_BASE, the three time bases are 50% square waves, all starting low after reset. The fast one has a half period of H cycles, the mid one 4·H, the slow one 20·H. They change level on clock edges that are multiples of H.
- R3: Mode bits [1:0] pick the carry source: 00 selects slow, 01 mid, 10 fast, 11 slow. This applies while mode bit 3 is 0.
- R4: Mode bit 2 picks the interrupt source: 0 selects mid, 1 selects fast. A falling edge of the chosen source on edge n gives irq_o high for exactly the cycle after edge n+1.
- R5: A rising edge of the carry source on edge n sets the flag at edge n+1. The flag then holds until a test.
- R6: While test_i is high, carry_rd_o shows the flag. The flag is 0 from the next edge on.
- R7: A test in the cycle where a set event is pending returns 1, and the flag still ends up cleared.
- R8: After reset the flag reads 0 until the first set. run_o rises one cycle after the first slow rising edge and then stays high.
- R9: A rising edge on ce_i arms a pending request. The next carry set event then gives ce_rst_o high for exactly one cycle, at the same time as the flag is set. Later set events give no further pulses.
- R10: A mode write alters no counter and produces no edge by itself. The new selection acts from the next edge of the newly chosen source.
- R11: Mode bit 3 set to 1 routes the zero-cross input to both functions, through a 2-flop synchroniser. The internal time bases then have no effect on the flag or on irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wd_i | input | 4 | Mode register write data |
| zc_i | input | 1 | External zero-cross pulse, asynchronous |
| ce_i | input | 1 | Chip-enable level |
| test_i | input | 1 | Test of the carry flag (read and clear) |
| carry_rd_o | output | 1 | Carry flag value returned by a test |
| irq_o | output | 1 | Timer interrupt request pulse |
| run_o | output | 1 | Program-start strobe after power-on |
| ce_rst_o | output | 1 | Chip-enable reset pulse, aligned to a carry set |

## Verification
The bench builds the block with HALF_BASE = 4 and the default ratios of 4 and 5. With these values the fast base toggles every 4 cycles and the slow base has a period of 160 cycles. Power-on start, two slow carry periods, a switch to the fast bases, a chip-enable reset and an external zero-cross episode therefore all fit within about 360 cycles. This small divider also makes it possible to place a test exactly on the cycle of a pending set event, and to place a mode write just before a falling edge of the new source.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MODE_W = 4;
  localparam int N_BASE = 3;
  localparam int N_SRC  = N_BASE + 1;

  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;

  function automatic src_e pick_carry(logic [MODE_W-1:0] mode);
    if (mode[3]) return SRC_EXT;
    case (mode[1:0])
      2'b01:   return SRC_MID;
      2'b10:   return SRC_FAST;
      default: return SRC_SLOW;
    endcase
  endfunction

  function automatic src_e pick_irq(logic [MODE_W-1:0] mode);
    if (mode[3]) return SRC_EXT;
    return mode[2] ? SRC_FAST : SRC_MID;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int HALF_BASE = 20000,
  parameter int DIV_MID   = 4,
  parameter int DIV_SLOW  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [N_BASE-1:0] pulse_o
);
  localparam int CW = (HALF_BASE > 1) ? $clog2(HALF_BASE) : 1;

  logic [CW-1:0] base_q;
  logic          tick;

  assign tick = (base_q == CW'(HALF_BASE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= '0;
    else if (tick) base_q <= '0;
    else           base_q <= base_q + 1'b1;
  end

  // one tick counter per time base; all aligned since they share reset and tick
  for (genvar g = 0; g < N_BASE; g++) begin : g_stage
    localparam int HALF = (g == 0) ? 1 : ((g == 1) ? DIV_MID : DIV_MID * DIV_SLOW);
    localparam int W    = $clog2(2 * HALF);
    logic [W-1:0] c_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   c_q <= '0;
      else if (tick) c_q <= (c_q == W'(2 * HALF - 1)) ? '0 : c_q + 1'b1;
    end

    assign pulse_o[g] = (c_q >= W'(HALF));
  end
endmodule

// File: rtl/tmr_edge_bank.sv
module tmr_edge_bank #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/tmr_carry_ff.sv
module tmr_carry_ff (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic test_i,
  output logic rd_o,
  output logic flag_o
);
  logic flag_q;

  // a test wins over a coincident set; the set is still reported
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (test_i) flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
  end

  assign rd_o   = test_i & (flag_q | set_i);
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_carry_int.sv
module tmr_carry_int
  import tmr_pkg::*;
#(
  parameter int HALF_BASE = 20000,
  parameter int DIV_MID   = 4,
  parameter int DIV_SLOW  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [3:0] mode_wd_i,
  input  logic       zc_i,
  input  logic       ce_i,
  input  logic       test_i,
  output logic       carry_rd_o,
  output logic       irq_o,
  output logic       run_o,
  output logic       ce_rst_o
);
  logic [MODE_W-1:0] mode_q;
  logic [1:0]        zc_sync_q;
  logic [N_BASE-1:0] base_pulse;
  logic [N_SRC-1:0]  src_lvl, src_rise, src_fall;
  src_e              carry_sel, irq_sel;
  logic              carry_set, carry_flag;
  logic              irq_q, run_q, ce_prev_q, ce_pend_q, ce_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_wd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) zc_sync_q <= '0;
    else         zc_sync_q <= {zc_sync_q[0], zc_i};
  end

  tmr_prescaler #(
    .HALF_BASE(HALF_BASE),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_o(base_pulse)
  );

  assign src_lvl = {zc_sync_q[1], base_pulse};

  // edges are taken per source, so a mode switch never fabricates one
  tmr_edge_bank #(.N(N_SRC)) u_edges (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (src_lvl),
    .rise_o(src_rise),
    .fall_o(src_fall)
  );

  assign carry_sel = pick_carry(mode_q);
  assign irq_sel   = pick_irq(mode_q);
  assign carry_set = src_rise[carry_sel];

  tmr_carry_ff u_carry (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (carry_set),
    .test_i(test_i),
    .rd_o  (carry_rd_o),
    .flag_o(carry_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      run_q     <= 1'b0;
      ce_prev_q <= 1'b0;
      ce_pend_q <= 1'b0;
      ce_rst_q  <= 1'b0;
    end else begin
      irq_q     <= src_fall[irq_sel];
      run_q     <= run_q | src_rise[SRC_SLOW];
      ce_prev_q <= ce_i;
      ce_rst_q  <= carry_set & ce_pend_q;
      if (ce_i && !ce_prev_q)         ce_pend_q <= 1'b1;
      else if (carry_set && ce_pend_q) ce_pend_q <= 1'b0;
    end
  end

  assign irq_o    = irq_q;
  assign run_o    = run_q;
  assign ce_rst_o = ce_rst_q;
endmodule

// File: rtl/tmr_carry_int_chk.sv
module tmr_carry_int_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic test_i,
  input logic carry_flag,
  input logic carry_rd_o,
  input logic irq_o,
  input logic run_o,
  input logic ce_rst_o
);
  assert_irq_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_flag_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_flag && !test_i) |=> carry_flag);

  assert_test_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_i |=> !carry_flag);

  assert_test_reads_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && carry_flag) |-> carry_rd_o);

  assert_run_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);

  assert_ce_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_rst_o |=> !ce_rst_o);
endmodule

bind tmr_carry_int tmr_carry_int_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .test_i    (test_i),
  .carry_flag(carry_flag),
  .carry_rd_o(carry_rd_o),
  .irq_o     (irq_o),
  .run_o     (run_o),
  .ce_rst_o  (ce_rst_o)
);

// File: tb/tmr_carry_int_bench.sv
module tmr_carry_int_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_we_i = 1'b0;
  logic [3:0] mode_wd_i = '0;
  logic       zc_i = 1'b0;
  logic       ce_i = 1'b0;
  logic       test_i = 1'b0;
  logic       carry_rd_o, irq_o, run_o, ce_rst_o;

  int total = 0;
  int bad = 0;
  int ecnt = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) ecnt <= ecnt + 1;

  tmr_carry_int #(.HALF_BASE(HB)) u_tmr_carry_int (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_we_i (mode_we_i),
    .mode_wd_i (mode_wd_i),
    .zc_i      (zc_i),
    .ce_i      (ce_i),
    .test_i    (test_i),
    .carry_rd_o(carry_rd_o),
    .irq_o     (irq_o),
    .run_o     (run_o),
    .ce_rst_o  (ce_rst_o)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, ecnt, act, exp);
    end
  endtask

  task automatic go(int n);
    do @(negedge clk_i); while (ecnt != n);
  endtask

  task automatic do_test(int n, int exp, string tag);
    go(n);
    test_i = 1'b1;
    #1 check(tag, int'(carry_rd_o), exp);
    @(posedge clk_i);
    #1 test_i = 1'b0;
  endtask

  task automatic write_mode(int n, logic [3:0] m);
    go(n);
    mode_we_i = 1'b1;
    mode_wd_i = m;
    @(posedge clk_i);
    #1 mode_we_i = 1'b0;
  endtask

  // scoreboard monitor: every irq pulse must match the next expected cycle
  always @(negedge clk_i) begin
    if (rst_ni && irq_o && !done) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected irq at cycle %0d: actual=1 expected=0", ecnt);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != ecnt) begin
          bad++;
          $display("FAIL R4 irq cycle: actual=%0d expected=%0d", ecnt, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R2/R4: mid base falls every 32 cycles -> irq at 32j+1
    for (int j = 1; j <= 8; j++) exp_q.push_back(32 * j + 1);
    // R10: after the switch to fast irq, fast falls every 8 cycles
    for (int c = 265; c <= 321; c += 8) if (c != 257) exp_q.push_back(c);
    // R11: zero-cross fall
    exp_q.push_back(348);

    repeat (3) @(negedge clk_i);
    check("R1 carry_rd", int'(carry_rd_o), 0);
    check("R1 irq", int'(irq_o), 0);
    check("R1 run", int'(run_o), 0);
    check("R1 ce_rst", int'(ce_rst_o), 0);
    rst_ni = 1'b1;

    do_test(79, 0, "R8 no set before first slow rise");
    go(80);
    check("R8 run before rise", int'(run_o), 0);
    test_i = 1'b1;
    #1 check("R7 coincident test", int'(carry_rd_o), 1);
    @(posedge clk_i);
    #1 test_i = 1'b0;
    go(81);
    check("R8 run after rise", int'(run_o), 1);
    do_test(85, 0, "R6 cleared by coincident test");
    do_test(250, 1, "R5 flag held until test");
    do_test(251, 0, "R6 cleared after test");

    write_mode(260, 4'b0110);
    do_test(266, 0, "R10 switch alone sets nothing");
    do_test(270, 1, "R3 fast carry source");
    do_test(271, 0, "R6 cleared fast");

    go(302);
    ce_i = 1'b1;
    go(305);
    check("R9 ce_rst pending", int'(ce_rst_o), 0);
    go(309);
    check("R9 ce_rst on set", int'(ce_rst_o), 1);
    go(310);
    check("R9 ce_rst single", int'(ce_rst_o), 0);
    go(317);
    check("R9 no repeat", int'(ce_rst_o), 0);

    write_mode(320, 4'b1000);
    do_test(325, 1, "R5 flag held across mode write");
    go(330);
    zc_i = 1'b1;
    do_test(331, 0, "R11 synchroniser delay");
    do_test(333, 1, "R11 zero-cross sets carry");
    do_test(340, 0, "R11 internal base ignored");
    go(345);
    zc_i = 1'b0;
    go(360);
    done = 1'b1;
    check("R4 all irqs seen", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule